// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs a 12-bit serial sampling converter from the system clock. It produces the converter's active-low conversion strobe and its serial clock, collects the twelve returned bits, most significant first, and presents them as one parallel word with a single-cycle valid pulse. The serial clock is the system clock divided by a programmable amount. The number of serial clock periods in one frame is also programmable, from 16 upward. Lengthening the frame lowers the sample rate without slowing the serial clock.

Each frame starts when the strobe falls. A mode input decides what the strobe does after that. In the powered mode it returns high after one serial period, so the converter stays awake. In the power-down mode it is held low past the thirteenth serial clock, so the converter sleeps until the strobe rises again. It then rises three periods before the frame ends. A frame is started by a start pulse or by a free-running enable. In both cases the strobe first has to have been high for at least three serial periods. A start that arrives before then, or while a frame is running, is held and served later. Configuration is captured when each frame begins.

Top module: `sadc_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `adc_conv` is 1, `adc_sclk` is 0, `result_valid` is 0 and `result` is 0.
- R2: During a frame, `adc_sclk` is high for `cfg_div`+1 system cycles and then low for `cfg_div`+1 system cycles. One serial period is therefore P = 2·(`cfg_div`+1) cycles, and each period begins with a rising edge.
- R3: A frame begins with `adc_conv` falling in the same cycle as the first rising edge of `adc_sclk`. It contains exactly N serial periods (N = effective frame length). With `free_run` held high, consecutive falling edges of `adc_conv` are exactly N·P cycles apart.
- R4: With `cfg_pdn` = 0, `adc_conv` rises P cycles after it fell, at the start of period 2.
- R5: With `cfg_pdn` = 1, `adc_conv` is still low at the 13th rising edge of `adc_sclk`. It rises (N−3)·P cycles after it fell, at the start of period N−2.
- R6: Every falling edge of `adc_conv` follows at least 3·P consecutive cycles with `adc_conv` high, including the first frame after reset.
- R7: The bit present on `adc_sdo` during periods 2 through 13 is D11 through D0. With `cfg_fall_edge` = 0, the bit for period p is sampled at the rising edge that starts period p. With `cfg_fall_edge` = 1, it is sampled at the falling edge inside period p. `result` equals {D11..D0}.
- R8: `result_valid` is a one-cycle pulse, exactly once per frame. It is high 12·P cycles after `adc_conv` falls with `cfg_fall_edge` = 0, and 12·P+`cfg_div`+1 cycles after with `cfg_fall_edge` = 1.
- R9: A `start` pulse that arrives during a frame or during the acquisition interval is neither lost nor repeated. It produces exactly one more frame, which begins as soon as R6 allows.
- R10: A `cfg_frame_len` below 16 is treated as 16.
- R11: Without `start` or `free_run`, no frame begins: `adc_conv` stays 1 and `adc_sclk` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request for one frame |
| free_run | input | 1 | Start frames back to back while high |
| cfg_frame_len | input | LEN_W | Serial periods per frame (minimum 16) |
| cfg_div | input | DIV_W | Half serial period in system cycles, minus one |
| cfg_pdn | input | 1 | 1: converter sleeps each frame; 0: stays powered |
| cfg_fall_edge | input | 1 | 0: sample data on rising edge; 1: on falling edge |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Conversion strobe, falls to start a frame |
| adc_sclk | output | 1 | Serial clock to the converter, rests low |
| result | output | 12 | Last converted word |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Some rules hold on every cycle and are checked by the assertions:
- the length of each high phase of the serial clock;
- the minimum strobe-high time before every falling edge;
- the strobe level at the thirteenth serial rising edge, which is the power-down decision;
- the single-cycle shape of the valid pulse;
- the reset levels.

Other behaviour can only be shown by bench scenarios: the captured word matching what the converter model sent under both sampling edges, the exact cycle offsets of the strobe's rising edge and of the valid pulse, back-to-back frame spacing in free-running mode, clamping of short frame lengths, and start requests deferred across a running frame.

// File: rtl/sadc_seq_pkg.sv
package sadc_seq_pkg;

    localparam int SAMPLE_BITS    = 12;
    localparam int FIRST_DATA_PER = 2;
    localparam int LAST_DATA_PER  = 13;
    localparam int ACQ_PERIODS    = 3;
    localparam int MIN_FRAME      = 16;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cap_edge_e;

    // true when serial period p carries one of the converter's data bits
    function automatic logic in_data_window(input int p);
        return (p >= FIRST_DATA_PER) && (p <= LAST_DATA_PER);
    endfunction

endpackage

// File: rtl/sadc_seq_timer.sv
module sadc_seq_timer
    import sadc_seq_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             busy,
    output logic             rise_evt,
    output logic             fall_evt,
    output logic             frame_end,
    output logic [LEN_W-1:0] period
);

    seq_state_e       st;
    logic [DIV_W-1:0] ph;
    logic             half;   // 0: high phase, 1: low phase
    logic             ph_done;

    assign busy      = (st == SEQ_RUN);
    assign ph_done   = busy && (ph == div);
    assign fall_evt  = ph_done && !half;
    assign rise_evt  = ph_done && half && (period != len);
    assign frame_end = ph_done && half && (period == len);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            ph     <= '0;
            half   <= 1'b0;
            period <= '0;
            sclk   <= 1'b0;
        end else if (launch) begin
            st     <= SEQ_RUN;
            ph     <= '0;
            half   <= 1'b0;
            period <= LEN_W'(1);
            sclk   <= 1'b1;
        end else if (busy) begin
            if (ph_done) begin
                ph <= '0;
                if (!half) begin
                    half <= 1'b1;
                    sclk <= 1'b0;
                end else if (period == len) begin
                    st   <= SEQ_IDLE;
                    half <= 1'b0;
                end else begin
                    half   <= 1'b0;
                    period <= period + LEN_W'(1);
                    sclk   <= 1'b1;
                end
            end else begin
                ph <= ph + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/sadc_seq_ctl.sv
module sadc_seq_ctl
    import sadc_seq_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             free_run,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             busy,
    input  logic             frame_end,
    input  logic             rise_evt,
    input  logic [LEN_W-1:0] period,
    input  logic [LEN_W-1:0] len_q,
    input  logic             pdn_q,
    output logic             launch,
    output logic             conv
);

    localparam int HI_W = DIV_W + 3;

    logic [HI_W-1:0]  hi_cnt;
    logic [HI_W-1:0]  acq_min;
    logic [LEN_W-1:0] rise_per;
    logic             pending;
    logic             acq_ok;

    assign acq_min  = HI_W'(2 * ACQ_PERIODS) * (HI_W'(cfg_div) + HI_W'(1));
    assign acq_ok   = hi_cnt >= (acq_min - HI_W'(1));
    assign rise_per = pdn_q ? (len_q - LEN_W'(ACQ_PERIODS - 1))
                            : LEN_W'(FIRST_DATA_PER);
    assign launch   = (pending || start || free_run) && (!busy || frame_end) && acq_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (launch) begin
            pending <= 1'b0;
        end else if (start) begin
            pending <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv <= 1'b1;
        end else if (launch) begin
            conv <= 1'b0;
        end else if (rise_evt && ((period + LEN_W'(1)) == rise_per)) begin
            conv <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (conv) begin
            if (hi_cnt != '1) hi_cnt <= hi_cnt + HI_W'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

endmodule

// File: rtl/sadc_seq_capture.sv
module sadc_seq_capture
    import sadc_seq_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rise_evt,
    input  logic                   fall_evt,
    input  logic [LEN_W-1:0]       period,
    input  logic                   fall_edge,
    input  logic                   sdo,
    output logic [SAMPLE_BITS-1:0] result,
    output logic                   valid
);

    logic [SAMPLE_BITS-2:0] shreg;
    logic                   take;
    logic                   last;
    int                     p_cur;

    always_comb begin
        p_cur = int'(period);
        if (cap_edge_e'(fall_edge) == EDGE_FALL) begin
            take = fall_evt && in_data_window(p_cur);
            last = fall_evt && (p_cur == LAST_DATA_PER);
        end else begin
            // the rising edge seen here opens period p_cur+1
            take = rise_evt && in_data_window(p_cur + 1);
            last = rise_evt && ((p_cur + 1) == LAST_DATA_PER);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= take && last;
            if (take) shreg <= {shreg[SAMPLE_BITS-3:0], sdo};
            if (take && last) result <= {shreg, sdo};
        end
    end

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_seq_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int DIV_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   free_run,
    input  logic [LEN_W-1:0]       cfg_frame_len,
    input  logic [DIV_W-1:0]       cfg_div,
    input  logic                   cfg_pdn,
    input  logic                   cfg_fall_edge,
    input  logic                   adc_sdo,
    output logic                   adc_conv,
    output logic                   adc_sclk,
    output logic [SAMPLE_BITS-1:0] result,
    output logic                   result_valid
);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] div;
        logic             pdn;
        logic             fedge;
    } frame_cfg_t;

    frame_cfg_t       cfg_q;
    logic [LEN_W-1:0] len_eff;
    logic             launch;
    logic             busy;
    logic             rise_evt;
    logic             fall_evt;
    logic             frame_end;
    logic [LEN_W-1:0] period;

    assign len_eff = (cfg_frame_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : cfg_frame_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{len: LEN_W'(MIN_FRAME), div: '0, pdn: 1'b0, fedge: 1'b0};
        end else if (launch) begin
            cfg_q <= '{len: len_eff, div: cfg_div, pdn: cfg_pdn, fedge: cfg_fall_edge};
        end
    end

    sadc_seq_ctl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .free_run  (free_run),
        .cfg_div   (cfg_div),
        .busy      (busy),
        .frame_end (frame_end),
        .rise_evt  (rise_evt),
        .period    (period),
        .len_q     (cfg_q.len),
        .pdn_q     (cfg_q.pdn),
        .launch    (launch),
        .conv      (adc_conv)
    );

    sadc_seq_timer #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .len       (cfg_q.len),
        .div       (cfg_q.div),
        .sclk      (adc_sclk),
        .busy      (busy),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .frame_end (frame_end),
        .period    (period)
    );

    sadc_seq_capture #(.LEN_W(LEN_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .period    (period),
        .fall_edge (cfg_q.fedge),
        .sdo       (adc_sdo),
        .result    (result),
        .valid     (result_valid)
    );

endmodule

// File: rtl/sadc_seq_chk.sv
module sadc_seq_chk
    import sadc_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_conv,
    input logic             adc_sclk,
    input logic             result_valid,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_pdn
);

    localparam int HC_W = DIV_W + 4;

    logic [HC_W-1:0]  hc;   // consecutive cycles with the strobe high
    logic [DIV_W:0]   shc;  // consecutive cycles with the serial clock high
    logic [15:0]      rc;   // serial rising edges since the strobe fell
    logic             cp;
    logic             sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            hc  <= '0;
            shc <= '0;
            rc  <= '0;
            cp  <= 1'b1;
            sp  <= 1'b0;
        end else begin
            cp <= adc_conv;
            sp <= adc_sclk;
            if (adc_conv) begin
                if (hc != '1) hc <= hc + HC_W'(1);
            end else begin
                hc <= '0;
            end
            if (adc_sclk) begin
                if (shc != '1) shc <= shc + (DIV_W+1)'(1);
            end else begin
                shc <= '0;
            end
            if (cp && !adc_conv) rc <= 16'd1;
            else if (!sp && adc_sclk && rc != 16'hFFFF) rc <= rc + 16'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (adc_conv && !adc_sclk && !result_valid));

    a_r2_sclk_high_phase: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sclk) |-> (shc == ((DIV_W+1)'(cfg_div) + (DIV_W+1)'(1))));

    a_r6_acq_time: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_conv) |-> (hc >= (HC_W'(2 * ACQ_PERIODS) * (HC_W'(cfg_div) + HC_W'(1)))));

    a_r5_pdn_decision: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_sclk) && !$fell(adc_conv) && rc == 16'd12) |-> (adc_conv == !cfg_pdn));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

endmodule

bind sadc_seq sadc_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_conv     (adc_conv),
    .adc_sclk     (adc_sclk),
    .result_valid (result_valid),
    .cfg_div      (cfg_div),
    .cfg_pdn      (cfg_pdn)
);

// File: tb/tb_sadc_seq.sv
module tb_sadc_seq;

    localparam int LEN_W = 11;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             free_run = 1'b0;
    logic [LEN_W-1:0] cfg_frame_len = 11'd16;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_pdn = 1'b0;
    logic             cfg_fall_edge = 1'b0;
    logic             adc_sdo = 1'b0;
    logic             adc_conv;
    logic             adc_sclk;
    logic [11:0]      result;
    logic             result_valid;

    sadc_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W)) dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .free_run      (free_run),
        .cfg_frame_len (cfg_frame_len),
        .cfg_div       (cfg_div),
        .cfg_pdn       (cfg_pdn),
        .cfg_fall_edge (cfg_fall_edge),
        .adc_sdo       (adc_sdo),
        .adc_conv      (adc_conv),
        .adc_sclk      (adc_sclk),
        .result        (result),
        .result_valid  (result_valid)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor and converter model, evaluated away from the active edge
    int         cyc = 0;
    int         last_fall = 0, prev_fall = 0, fall_count = 0;
    int         last_crise = 0;
    int         valid_count = 0, last_valid = 0;
    int         rises = 0;
    int         hi_run = 0, exp_half = 1, sclk_bad = 0;
    logic [11:0] last_result = '0;
    logic [11:0] adc_word = '0;
    logic [11:0] word_sh = '0;
    int         bit_idx = 12;
    logic       conv_p = 1'b1, sclk_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (conv_p && !adc_conv) begin
                prev_fall = last_fall;
                last_fall = cyc;
                fall_count++;
                rises = 0;
                word_sh = adc_word;
                bit_idx = 0;
            end
            if (!conv_p && adc_conv) last_crise = cyc;
            if (!sclk_p && adc_sclk) rises++;
            if (adc_sclk) hi_run++;
            if (sclk_p && !adc_sclk) begin
                if (hi_run != exp_half) sclk_bad++;
                hi_run = 0;
                if (bit_idx < 12) adc_sdo = word_sh[11 - bit_idx];
                else adc_sdo = 1'b0;
                bit_idx++;
            end
            if (result_valid) begin
                valid_count++;
                last_valid = cyc;
                last_result = result;
            end
        end
        conv_p = adc_conv;
        sclk_p = adc_sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int n);
        return (n < 16) ? 16 : n;
    endfunction

    function automatic int per_len(input int d);
        return 2 * (d + 1);
    endfunction

    function automatic int exp_valid_off(input int d, input bit fe);
        return 12 * per_len(d) + (fe ? d + 1 : 0);
    endfunction

    function automatic int exp_conv_low(input int d, input int n, input bit pd);
        return pd ? (eff_len(n) - 3) * per_len(d) : per_len(d);
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_fall(input int nf);
        for (int i = 0; i < 5000 && fall_count <= nf; i++) @(negedge clk);
    endtask

    task automatic run_frame(input int d, input int n, input bit pd, input bit fe,
                             input logic [11:0] w);
        int nf, nv, ne, p;
        @(negedge clk);
        cfg_div = DIV_W'(d);
        cfg_frame_len = LEN_W'(n);
        cfg_pdn = pd;
        cfg_fall_edge = fe;
        exp_half = d + 1;
        adc_word = w;
        sclk_bad = 0;
        nf = fall_count;
        nv = valid_count;
        ne = eff_len(n);
        p = per_len(d);
        pulse_start();
        wait_fall(nf);
        repeat (ne * p + 8) @(negedge clk);
        check(fall_count == nf + 1, "R3 one frame per start", fall_count - nf, 1);
        check(rises == ne, "R3/R10 serial periods per frame", rises, ne);
        check(sclk_bad == 0, "R2 serial high phase length", sclk_bad, 0);
        check(valid_count == nv + 1, "R8 one valid per frame", valid_count - nv, 1);
        check(last_result == w, "R7 captured word", int'(last_result), int'(w));
        check(last_valid - last_fall == exp_valid_off(d, fe), "R8 valid timing",
              last_valid - last_fall, exp_valid_off(d, fe));
        if (pd)
            check(last_crise - last_fall == exp_conv_low(d, n, pd), "R5 power-down strobe low time",
                  last_crise - last_fall, exp_conv_low(d, n, pd));
        else
            check(last_crise - last_fall == exp_conv_low(d, n, pd), "R4 powered strobe low time",
                  last_crise - last_fall, exp_conv_low(d, n, pd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nf, rel, seed;
        seed = $urandom(32'd2024);
        cfg_div = DIV_W'(1);
        exp_half = 2;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: outputs in the cycle after reset
        @(negedge clk);
        check(adc_conv == 1'b1, "R1 strobe high", int'(adc_conv), 1);
        check(adc_sclk == 1'b0, "R1 serial clock low", int'(adc_sclk), 0);
        check(result_valid == 1'b0, "R1 valid low", int'(result_valid), 0);
        check(result == 12'd0, "R1 result zero", int'(result), 0);

        // R11: nothing happens without a request
        repeat (60) @(negedge clk);
        check(fall_count == 0, "R11 no frame without request", fall_count, 0);
        check(adc_sclk == 1'b0 && adc_conv == 1'b1, "R11 idle levels",
              int'({adc_conv, adc_sclk}), 2);

        // directed frames in both modes and both sampling edges
        run_frame(0, 16, 1'b0, 1'b0, 12'hA5C);
        run_frame(0, 16, 1'b1, 1'b0, 12'h800);
        run_frame(1, 16, 1'b1, 1'b1, 12'h001);
        run_frame(2, 20, 1'b0, 1'b1, 12'hFFF);
        run_frame(3, 160, 1'b1, 1'b0, 12'h3C6);
        // R10: short lengths clamp to 16
        run_frame(1, 5, 1'b1, 1'b1, 12'h5A5);
        run_frame(0, 0, 1'b0, 1'b0, 12'h6B2);

        // constrained random frames
        for (int i = 0; i < 14; i++) begin
            run_frame(int'($urandom_range(3, 0)), int'($urandom_range(40, 12)),
                      1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                      12'($urandom));
        end

        // R9: starts during a frame are held and served once
        @(negedge clk);
        cfg_div = DIV_W'(1); cfg_frame_len = 11'd16; cfg_pdn = 1'b0; cfg_fall_edge = 1'b0;
        exp_half = 2;
        nf = fall_count;
        pulse_start();
        wait_fall(nf);
        repeat (10) @(negedge clk);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (2 * 16 * 4 + 60) @(negedge clk);
        check(fall_count == nf + 2, "R9 deferred start runs once", fall_count - nf, 2);
        check(last_fall - prev_fall == 64, "R9 deferred frame begins at frame end",
              last_fall - prev_fall, 64);

        // R3: free-running spacing, with power-down between frames
        @(negedge clk);
        cfg_div = DIV_W'(1); cfg_frame_len = 11'd20; cfg_pdn = 1'b1; cfg_fall_edge = 1'b0;
        adc_word = 12'h9E1;
        free_run = 1'b1;
        nf = fall_count;
        wait_fall(nf);
        for (int k = 1; k <= 3; k++) begin
            wait_fall(nf + k);
            check(last_fall - prev_fall == 80, "R3 free-run frame spacing",
                  last_fall - prev_fall, 80);
            check(last_result == 12'h9E1, "R7 free-run word", int'(last_result), 16'h9E1);
        end
        free_run = 1'b0;
        repeat (120) @(negedge clk);
        nf = fall_count;
        repeat (100) @(negedge clk);
        check(fall_count == nf, "R11 free-run stops when cleared", fall_count - nf, 0);

        // R6: first frame after reset waits for the acquisition time
        @(negedge clk);
        rst = 1'b1;
        cfg_div = DIV_W'(3); cfg_frame_len = 11'd16; cfg_pdn = 1'b0;
        exp_half = 4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rel = cyc;
        nf = fall_count;
        pulse_start();
        wait_fall(nf);
        check(fall_count == nf + 1, "R6/R9 early start not lost", fall_count - nf, 1);
        check(last_fall - rel >= 24, "R6 acquisition time after reset", last_fall - rel, 24);
        repeat (16 * 8 + 10) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule